// File: doc/BRIEF.md
# Cartridge Interval Timer

This block is a periodic interrupt source that sits on the cartridge side of an 8-bit I/O port bus. Software programs a single control byte. The top bit switches the timer on, and the seven low bits give a period value `p`. While the timer is on, it raises an interrupt request each time `2*(p+1)` slow ticks have passed. The slow tick is an enable derived inside the block by dividing the CPU clock by eight. With the default division, one interval therefore lasts `16*(p+1)` CPU clock cycles.

The request is a level. It stays high until the interrupt acknowledge input clears it, and further expiries while it is high do not queue up. Any write to the control byte restarts the interval from its beginning, including the phase of the slow tick. The first request after a write therefore arrives exactly one full interval later. While the enable bit is clear, the counter is parked at its reload value and nothing expires.

Top module: `cit_timer`

## Requirements
- R1: After reset, `irq` is low and a read of the control byte at port 0xD6 returns 0x00 (timer off).
- R2: A cycle with `io_rd` high, `io_wr` low and `io_addr` = 0xD6 makes `io_rdata` show the last byte written to 0xD6 on the following cycle. Any other cycle leaves `io_rdata` at 0x00.
- R3: With bit 7 of the control byte set and bits 6..0 equal to `p`, `irq` first rises `16*(p+1)` clock cycles after the clock edge that took the write. After that, an expiry falls every `16*(p+1)` cycles, so at p=127 the interval is 2048 cycles.
- R4: The counter steps only on a tick that comes once every 8 clock cycles. The tick phase restarts at each write to 0xD6, and an expiry is only ever taken on a tick.
- R5: While bit 7 of the control byte is clear, no new interrupt request is raised, whatever the period bits hold.
- R6: Rewriting the control byte in the middle of an interval discards the elapsed part. The next request comes a full `16*(p+1)` cycles after the rewrite.
- R7: Once raised, `irq` stays high until a cycle with `irq_ack` high, and drops on the next cycle if no expiry coincides. Expiries while it is high do not accumulate, so one acknowledge clears them all.
- R8: When an expiry and `irq_ack` fall in the same cycle, the expiry wins and `irq` is high on the next cycle.
- R9: A write strobe to any address other than 0xD6, or bus data presented at 0xD6 without the write strobe, changes neither the control byte nor the interrupt timing.
- R10: Clearing the enable bit while a request is pending leaves `irq` high until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read data, registered, zero when not selected |
| irq_ack | input | 1 | Clears a pending interrupt request |
| irq | output | 1 | Interrupt request level |

## Verification
The bench builds the block with its default parameters: an 8-bit port bus, the control byte at 0xD6 and a divide-by-8 tick. With these values, every interval from the shortest (16 cycles at p=0) to the longest (2048 cycles at p=127) fits in a short run, so both ends of the period range are timed to the exact cycle. The short intervals also bring into reach coincident expiry-and-acknowledge cycles and rewrites that land mid-interval. A cycle model in the bench, driven from the same port activity, tracks the request level and read data on every cycle through the random phase.

// File: rtl/cit_pkg.sv
package cit_pkg;

    // Slow ticks per unit of the programmed period value.
    localparam int unsigned TICKS_PER_STEP = 2;

    // Decoded bus operation for one cycle; write takes priority.
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2
    } bus_op_e;

endpackage

// File: rtl/cit_prescaler.sv
module cit_prescaler #(
    parameter int unsigned DIVIDE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_clr,
    output logic tick
);

    localparam int unsigned PW = (DIVIDE > 1) ? $clog2(DIVIDE) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIVIDE - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_s;

    pre_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sync_clr || (s_q.phase == LAST)) begin
            s_d.phase = '0;
        end else begin
            s_d.phase = s_q.phase + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick = (s_q.phase == LAST);

    generate
        if (DIVIDE > 1) begin : g_gap_check
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R4
            AST_CLR_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
                sync_clr |=> !tick); // R4
        end
    endgenerate

endmodule

// File: rtl/cit_counter.sv
module cit_counter
    import cit_pkg::*;
#(
    parameter int unsigned PERIOD_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                load,
    input  logic [PERIOD_W-1:0] load_period,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    output logic                expire
);

    localparam int unsigned CNT_W = PERIOD_W + $clog2(TICKS_PER_STEP);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
    } cnt_s;

    cnt_s s_d, s_q;
    logic [CNT_W-1:0] reload_run;
    logic [CNT_W-1:0] reload_new;

    function automatic logic [CNT_W-1:0] reload_of(input logic [PERIOD_W-1:0] p);
        logic [CNT_W-1:0] steps;
        steps = CNT_W'(p) + CNT_W'(1);
        return CNT_W'(steps * CNT_W'(TICKS_PER_STEP)) - CNT_W'(1);
    endfunction

    always_comb begin
        reload_run = reload_of(period);
        reload_new = reload_of(load_period);
        s_d        = s_q;
        expire     = 1'b0;
        if (load) begin
            s_d.remain = reload_new;
        end else if (!enable) begin
            s_d.remain = reload_run;
        end else if (tick) begin
            if (s_q.remain == '0) begin
                expire     = 1'b1;
                s_d.remain = reload_run;
            end else begin
                s_d.remain = s_q.remain - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !expire); // R5
    AST_EXPIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> tick); // R4
    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expire); // R6

endmodule

// File: rtl/cit_ctrl_regs.sv
module cit_ctrl_regs
    import cit_pkg::*;
#(
    parameter int unsigned             ADDR_W    = 8,
    parameter int unsigned             DATA_W    = 8,
    parameter logic [ADDR_W-1:0]       CTRL_ADDR = ADDR_W'('hD6)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [DATA_W-1:0] ctrl,
    output logic              wr_hit,
    output logic [DATA_W-1:0] io_rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] rdata;
    } reg_s;

    reg_s    s_d, s_q;
    bus_op_e op;
    logic    sel;

    always_comb begin
        sel = (io_addr == CTRL_ADDR);
        if (io_wr) begin
            op = BUS_WRITE;
        end else if (io_rd) begin
            op = BUS_READ;
        end else begin
            op = BUS_IDLE;
        end
        wr_hit    = (op == BUS_WRITE) && sel;
        s_d       = s_q;
        s_d.rdata = '0;
        if (wr_hit) begin
            s_d.ctrl = io_wdata;
        end
        if ((op == BUS_READ) && sel) begin
            s_d.rdata = s_q.ctrl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl     = s_q.ctrl;
    assign io_rdata = s_q.rdata;

    AST_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && (io_addr == CTRL_ADDR)) |=> $stable(ctrl)); // R9
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> (io_rdata == '0)); // R2

endmodule

// File: rtl/cit_timer.sv
module cit_timer
    import cit_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 8,
    parameter int unsigned       DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'('hD6),
    parameter int unsigned       PRESCALE  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              irq_ack,
    output logic              irq
);

    localparam int unsigned PERIOD_W = DATA_W - 1;
    localparam int unsigned EN_BIT   = DATA_W - 1;

    typedef struct packed {
        logic req;
    } irq_s;

    irq_s              s_d, s_q;
    logic [DATA_W-1:0] ctrl;
    logic              wr_hit;
    logic              tick;
    logic              expire;

    cit_ctrl_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .ctrl     (ctrl),
        .wr_hit   (wr_hit),
        .io_rdata (io_rdata)
    );

    cit_prescaler #(
        .DIVIDE (PRESCALE)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_clr (wr_hit),
        .tick     (tick)
    );

    cit_counter #(
        .PERIOD_W (PERIOD_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .load        (wr_hit),
        .load_period (io_wdata[PERIOD_W-1:0]),
        .enable      (ctrl[EN_BIT]),
        .period      (ctrl[PERIOD_W-1:0]),
        .expire      (expire)
    );

    always_comb begin
        s_d = s_q;
        if (expire) begin
            s_d.req = 1'b1;
        end else if (irq_ack) begin
            s_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq = s_q.req;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq); // R7
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack && !expire) |=> !irq); // R7
    AST_EXPIRE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && irq_ack) |=> irq); // R8
    AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !expire) |=> !irq); // R5

endmodule

// File: tb/tb_cit_timer.sv
module tb_cit_timer;

    localparam int CLK_NS = 8;
    localparam logic [7:0] CTRL = 8'hD6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_rdata;
    logic       irq_ack = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Bench reference model state
    logic [7:0] m_reg = '0;
    int         m_cyc = 0;
    logic       m_irq = 1'b0;
    logic [7:0] m_rdata = '0;

    always #(CLK_NS/2) clk = ~clk;

    cit_timer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_rdata (io_rdata),
        .irq_ack  (irq_ack),
        .irq      (irq)
    );

    function automatic int interval_cycles(input logic [7:0] v);
        return 16 * (int'(v[6:0]) + 1);
    endfunction

    function automatic bit model_expires(input logic [7:0] v, input int cyc);
        return v[7] && (cyc > 0) && ((cyc % interval_cycles(v)) == 0);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Cycle model, compared shortly after each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg = '0; m_cyc = 0; m_irq = 1'b0; m_rdata = '0;
        end else begin
            bit ex;
            ex = 1'b0;
            m_rdata = (io_rd && !io_wr && io_addr == CTRL) ? m_reg : 8'h00;
            if (io_wr && io_addr == CTRL) begin
                m_reg = io_wdata;
                m_cyc = 0;
            end else begin
                m_cyc++;
                ex = model_expires(m_reg, m_cyc);
            end
            if (ex) m_irq = 1'b1;
            else if (irq_ack) m_irq = 1'b0;
            #2;
            check("R3 model irq", 32'(irq), 32'(m_irq));
            check("R2 model rdata", 32'(io_rdata), 32'(m_rdata));
        end
    end

    initial begin
        #(CLK_NS * 150000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        logic [7:0] rd;
        int ones;
        void'($urandom(32'd20240611));
        wait_cycles(5);
        rst_n = 1'b1;
        wait_cycles(2);

        // R1 reset state
        check("R1 irq after reset", 32'(irq), 32'd0);
        bus_read(CTRL, rd);
        check("R1 ctrl after reset", 32'(rd), 32'h00);

        // R2 read back, R5 disabled stays quiet
        bus_write(CTRL, 8'h25);
        bus_read(CTRL, rd);
        check("R2 read back", 32'(rd), 32'h25);
        bus_read(8'hD7, rd);
        check("R2 other address reads zero", 32'(rd), 32'h00);
        wait_cycles(16 * 38 * 3);
        check("R5 disabled no irq", 32'(irq), 32'd0);

        // R3 / R4 exact first interval, p=3 -> 64 cycles
        bus_write(CTRL, 8'h83);
        wait_cycles(63);
        check("R4 irq low one cycle before interval", 32'(irq), 32'd0);
        wait_cycles(1);
        check("R3 irq at 64 cycles", 32'(irq), 32'd1);

        // R7 hold without ack, no stacking
        wait_cycles(200);
        check("R7 irq held", 32'(irq), 32'd1);
        ack_pulse();
        check("R7 one ack clears all", 32'(irq), 32'd0);
        wait_cycles(55);
        check("R3 next expiry on period grid", 32'(irq), 32'd1);

        // R8 ack held continuously: expiry still shows for one cycle
        bus_write(CTRL, 8'h80);
        irq_ack = 1'b1;
        ones = 0;
        for (int i = 0; i < 160; i++) begin
            @(negedge clk);
            if (irq) ones++;
        end
        irq_ack = 1'b0;
        check("R8 expiry beats ack", 32'(ones), 32'd10);

        // R6 rewrite mid-interval restarts
        ack_pulse();
        bus_write(CTRL, 8'h81);
        wait_cycles(20);
        bus_write(CTRL, 8'h81);
        ones = 0;
        for (int i = 0; i < 31; i++) begin
            @(negedge clk);
            if (irq) ones++;
        end
        check("R6 no irq before full interval", 32'(ones), 32'd0);
        wait_cycles(1);
        check("R6 irq after full interval", 32'(irq), 32'd1);

        // R10 disable while pending keeps request
        bus_write(CTRL, 8'h01);
        wait_cycles(100);
        check("R10 pending kept after disable", 32'(irq), 32'd1);
        ack_pulse();
        check("R7 ack clears", 32'(irq), 32'd0);
        wait_cycles(300);
        check("R5 no irq while off", 32'(irq), 32'd0);

        // R9 ignored accesses
        bus_write(8'hD7, 8'hFF);
        bus_write(8'h56, 8'h80);
        @(negedge clk);
        io_addr = CTRL; io_wdata = 8'hFF;
        @(negedge clk);
        bus_read(CTRL, rd);
        check("R9 ctrl unchanged", 32'(rd), 32'h01);
        wait_cycles(200);
        check("R9 no irq from stray writes", 32'(irq), 32'd0);

        // R3 longest period, 2048 cycles
        bus_write(CTRL, 8'hFF);
        wait_cycles(2047);
        check("R3 max period not early", 32'(irq), 32'd0);
        wait_cycles(1);
        check("R3 max period expiry", 32'(irq), 32'd1);
        ack_pulse();

        // Random phase, checked by the cycle model
        for (int it = 0; it < 500; it++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel < 3) begin
                logic [7:0] v;
                v = 8'($urandom);
                if ($urandom_range(0, 3) != 0) v[6:4] = 3'b000;
                bus_write(CTRL, v);
            end else if (sel < 5) begin
                logic [7:0] a;
                a = 8'($urandom);
                if (a == CTRL) a = 8'hD5;
                bus_write(a, 8'($urandom));
            end else if (sel < 7) begin
                bus_read(($urandom_range(0, 1) == 0) ? CTRL : 8'hC0, rd);
            end else begin
                ack_pulse();
            end
            wait_cycles(int'($urandom_range(1, 200)));
        end

        wait_cycles(4);
        finish_run();
    end

endmodule